// File: doc/BRIEF.md
# Configuration Request Header Generator

This block sits on the register side of a root-complex bridge and turns plain host-bus accesses into configuration-request descriptors. Software first writes a target-header register holding the destination bus, device/function, a byte-enable field and a flag that forces that byte-enable field onto the request. It then reads or writes a 4 KiB configuration window. Each window access becomes one descriptor on a valid/ready request port. The descriptor carries bus, device/function, register number, byte enables, a write flag and 32 bits of write data. Read data comes back on a completion port.

The host bus uses a hold-until-acknowledge handshake. The host raises `hb_req` with address, data and strobes and keeps them steady until `hb_ack` is high at a rising clock edge. Only one configuration request is in flight at a time. A window write is acknowledged when its descriptor is accepted, and a window read is acknowledged when its completion returns. Any further window access waits until the outstanding completion arrives. Sub-dword writes are never narrowed by the block: software places the bytes on their lanes and chooses the byte enables.

Top module: `cfg_hdr_gen`

## Requirements
- R1: After reset `req_valid` is low and the header register reads back as zero.
- R2: A write to address 0x140 stores bits 20:0 of the write data in the header register. Reading 0x140 returns the stored value in bits 20:0 and zero in bits 31:21. Header layout: bits 7:0 device/function, bits 15:8 bus, bits 19:16 byte enables, bit 20 force flag.
- R3: An access at address 0x1000 + N (N below 0x1000) produces one descriptor whose bus and device/function come from the header register and whose register number is N bits 11:2.
- R4: When the force flag is set, the descriptor byte enables equal the header byte-enable field, for reads and for writes.
- R5: When the force flag is clear, a write uses `hb_wstrb` as its byte enables (bit i enables byte lane i) and a read uses 4'hF.
- R6: A window write sets `req_write` and carries all 32 bits of `hb_wdata` unchanged. A window read clears `req_write`.
- R7: While `req_valid` is high and `req_ready` is low, `req_valid` stays high and every descriptor field holds its value.
- R8: A window write is acknowledged in the cycle its descriptor is accepted. A window read is acknowledged in the cycle `cpl_valid` is high, with `hb_rdata` equal to `cpl_data`. Counted from the first negative edge after the host raises its request, the write acknowledge comes after ready-delay + 1 cycles and the read acknowledge after completion-delay + 2 cycles.
- R9: While a request's completion has not returned, no new descriptor is presented and a new window access is not acknowledged.
- R10: An access to an address that is neither 0x140 nor inside the window is acknowledged in its first cycle, reads as zero and does not change the header register.
- R11: Header register accesses are acknowledged in their first cycle even while a write completion is still outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| hb_req | input | 1 | Host access request, held until acknowledged |
| hb_we | input | 1 | Host access is a write |
| hb_addr | input | 13 | Host byte address |
| hb_wdata | input | 32 | Host write data |
| hb_wstrb | input | 4 | Host write strobes, one per byte lane |
| hb_ack | output | 1 | Access acknowledged this cycle |
| hb_rdata | output | 32 | Read data, valid with `hb_ack` |
| req_valid | output | 1 | Descriptor valid |
| req_ready | input | 1 | Descriptor accepted by the downstream logic |
| req_bus | output | 8 | Target bus number |
| req_devfn | output | 8 | Target device/function |
| req_regnum | output | 10 | Dword register number |
| req_be | output | 4 | Byte enables |
| req_write | output | 1 | 1 for a configuration write |
| req_wdata | output | 32 | Write data |
| cpl_valid | input | 1 | Completion returned |
| cpl_data | input | 32 | Completion read data |

## Verification
Some properties are checked on every cycle. A stalled descriptor must hold steady. No descriptor may appear while a completion is owed. A read must not be acknowledged without a completion, and a write must not be acknowledged without a descriptor handshake. The byte-enable choice at the start of each request is checked against the header in both force states. Other behaviour can only be shown by the bench's scenarios: the field mapping from header and offset, pass-through of write data, header readback and masking, the exact acknowledge latency, the length of the stall behind a slow completion, and the handling of stray addresses.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;
  localparam int DW     = 32;
  localparam int BEW    = DW / 8;
  localparam int WIN_AW = 12;
  localparam int RN_W   = WIN_AW - 2;

  typedef struct packed {
    logic           force_be;
    logic [BEW-1:0] be;
    logic [7:0]     bus;
    logic [7:0]     devfn;
  } hdr_t;

  localparam int HDR_W = $bits(hdr_t);

  typedef struct packed {
    logic [7:0]      bus;
    logic [7:0]      devfn;
    logic [RN_W-1:0] regnum;
    logic [BEW-1:0]  be;
    logic            write;
    logic [DW-1:0]   wdata;
  } desc_t;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} seq_st_e;
endpackage

// File: rtl/cfg_hdr_reg.sv
module cfg_hdr_reg
  import cfg_hdr_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output hdr_t          hdr
);
  hdr_t hdr_q, hdr_d;

  always_comb begin
    hdr_d = hdr_q;
    if (wr_en) hdr_d = hdr_t'(wdata[HDR_W-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hdr_q <= '0;
    else if (wr_en) hdr_q <= hdr_d;
  end

  assign hdr = hdr_q;

  // R2
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(hdr_q))
    else $error("header changed without a write");
endmodule

// File: rtl/cfg_req_seq.sv
module cfg_req_seq
  import cfg_hdr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            win_req,
  input  logic            we,
  input  logic [RN_W-1:0] regnum,
  input  logic [DW-1:0]   wdata,
  input  logic [BEW-1:0]  wstrb,
  input  hdr_t            hdr,
  output logic            win_ack,
  output logic [DW-1:0]   win_rdata,
  output logic            req_valid,
  input  logic            req_ready,
  output desc_t           desc,
  input  logic            cpl_valid,
  input  logic [DW-1:0]   cpl_data
);
  seq_st_e st_q, st_d;
  desc_t   desc_q, desc_d;
  logic    rd_q, rd_d;
  logic    ld_en;
  logic [BEW-1:0] be_sel;

  always_comb begin
    if (hdr.force_be) be_sel = hdr.be;
    else if (we)      be_sel = wstrb;
    else              be_sel = {BEW{1'b1}};
  end

  assign ld_en = (st_q == S_IDLE) && win_req;

  always_comb begin
    desc_d        = desc_q;
    desc_d.bus    = hdr.bus;
    desc_d.devfn  = hdr.devfn;
    desc_d.regnum = regnum;
    desc_d.be     = be_sel;
    desc_d.write  = we;
    desc_d.wdata  = wdata;
  end

  always_comb begin
    st_d      = st_q;
    rd_d      = rd_q;
    win_ack   = 1'b0;
    win_rdata = '0;
    case (st_q)
      S_IDLE: if (win_req) begin
        st_d = S_ISSUE;
        rd_d = !we;
      end
      S_ISSUE: if (req_ready) begin
        st_d    = S_WAIT;
        win_ack = !rd_q;
      end
      S_WAIT: if (cpl_valid) begin
        st_d = S_IDLE;
        if (rd_q) begin
          win_ack   = 1'b1;
          win_rdata = cpl_data;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      rd_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rd_q <= rd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     desc_q <= '0;
    else if (ld_en) desc_q <= desc_d;
  end

  assign req_valid = (st_q == S_ISSUE);
  assign desc      = desc_q;

  // Independent count of handshakes minus completions, for checking only.
  logic [1:0] owed_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owed_q <= '0;
    else owed_q <= owed_q + {1'b0, req_valid && req_ready} - {1'b0, cpl_valid && owed_q != 2'd0};
  end

  // R7
  desc_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(desc_q))
    else $error("descriptor moved while stalled");

  // R9
  one_owed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    owed_q != 2'd0 |-> !req_valid && owed_q == 2'd1)
    else $error("new request while completion owed");

  // R4
  be_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && $past(hdr.force_be) |-> desc_q.be == $past(hdr.be))
    else $error("forced byte enables not applied");

  // R5
  be_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) && !$past(hdr.force_be) && !desc_q.write |-> desc_q.be == {BEW{1'b1}})
    else $error("read byte enables not all set");
endmodule

// File: rtl/cfg_hdr_gen.sv
module cfg_hdr_gen
  import cfg_hdr_pkg::*;
#(
  parameter int                ADDR_W   = 13,
  parameter logic [ADDR_W-1:0] HDR_OFS  = 13'h0140,
  parameter logic [ADDR_W-1:0] WIN_BASE = 13'h1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hb_req,
  input  logic              hb_we,
  input  logic [ADDR_W-1:0] hb_addr,
  input  logic [DW-1:0]     hb_wdata,
  input  logic [BEW-1:0]    hb_wstrb,
  output logic              hb_ack,
  output logic [DW-1:0]     hb_rdata,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [7:0]        req_bus,
  output logic [7:0]        req_devfn,
  output logic [RN_W-1:0]   req_regnum,
  output logic [BEW-1:0]    req_be,
  output logic              req_write,
  output logic [DW-1:0]     req_wdata,
  input  logic              cpl_valid,
  input  logic [DW-1:0]     cpl_data
);
  localparam int PAGE_W = ADDR_W - WIN_AW;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic hit_hdr, hit_win, hdr_wr, win_req, win_ack;
  logic [DW-1:0] win_rdata;
  hdr_t  hdr;
  desc_t desc;

  assign hit_hdr = (hb_addr == HDR_OFS);
  assign hit_win = (hb_addr[ADDR_W-1:WIN_AW] == WIN_BASE[ADDR_W-1:WIN_AW]);
  assign hdr_wr  = hb_req && hb_we && hit_hdr;
  assign win_req = hb_req && hit_win;

  cfg_hdr_reg u_hdr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (hdr_wr),
    .wdata (hb_wdata),
    .hdr   (hdr)
  );

  cfg_req_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .win_req   (win_req),
    .we        (hb_we),
    .regnum    (hb_addr[WIN_AW-1:2]),
    .wdata     (hb_wdata),
    .wstrb     (hb_wstrb),
    .hdr       (hdr),
    .win_ack   (win_ack),
    .win_rdata (win_rdata),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .desc      (desc),
    .cpl_valid (cpl_valid),
    .cpl_data  (cpl_data)
  );

  always_comb begin
    hb_ack   = hb_req && (hit_win ? win_ack : 1'b1);
    hb_rdata = '0;
    if (hit_win)      hb_rdata = win_rdata;
    else if (hit_hdr) hb_rdata = {{(DW-HDR_W){1'b0}}, hdr};
  end

  assign req_bus    = desc.bus;
  assign req_devfn  = desc.devfn;
  assign req_regnum = desc.regnum;
  assign req_be     = desc.be;
  assign req_write  = desc.write;
  assign req_wdata  = desc.wdata;

  // R8
  rd_ack_cpl_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    hb_ack && hit_win && !hb_we |-> cpl_valid)
    else $error("read acknowledged without completion");

  // R8
  wr_ack_hs_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    hb_ack && hit_win && hb_we |-> req_valid && req_ready)
    else $error("write acknowledged without handshake");

  // R10
  stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    hb_req && !hit_win && !hit_hdr |-> hb_ack && hb_rdata == '0)
    else $error("stray access mishandled");
endmodule

// File: tb/tb_cfg_hdr_gen.sv
`timescale 1ns/1ps
module tb_cfg_hdr_gen;
  logic        clk, rst_n;
  logic        hb_req, hb_we;
  logic [12:0] hb_addr;
  logic [31:0] hb_wdata;
  logic [3:0]  hb_wstrb;
  logic        hb_ack;
  logic [31:0] hb_rdata;
  logic        req_valid, req_ready;
  logic [7:0]  req_bus, req_devfn;
  logic [9:0]  req_regnum;
  logic [3:0]  req_be;
  logic        req_write;
  logic [31:0] req_wdata;
  logic        cpl_valid;
  logic [31:0] cpl_data;

  cfg_hdr_gen dut (
    .clk(clk), .rst_n(rst_n), .hb_req(hb_req), .hb_we(hb_we), .hb_addr(hb_addr),
    .hb_wdata(hb_wdata), .hb_wstrb(hb_wstrb), .hb_ack(hb_ack), .hb_rdata(hb_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_bus(req_bus),
    .req_devfn(req_devfn), .req_regnum(req_regnum), .req_be(req_be),
    .req_write(req_write), .req_wdata(req_wdata), .cpl_valid(cpl_valid),
    .cpl_data(cpl_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // Completer model
  int          rdy_dly = 0;
  int          cpl_dly = 1;
  logic [31:0] cpl_pat = 32'h0;
  int          n_req   = 0;
  logic [7:0]  cap_bus, cap_devfn;
  logic [9:0]  cap_regnum;
  logic [3:0]  cap_be;
  logic        cap_write;
  logic [31:0] cap_wdata;

  initial begin
    req_ready = 1'b0;
    cpl_valid = 1'b0;
    cpl_data  = '0;
    forever begin
      @(negedge clk);
      if (req_valid) begin
        automatic logic [62:0] first = {req_bus, req_devfn, req_regnum, req_be, req_write, req_wdata};
        repeat (rdy_dly) @(negedge clk);
        if (rdy_dly > 0) begin
          check("R7 valid held", {31'b0, req_valid}, 32'd1);
          check("R7 fields held", {31'b0, first == {req_bus, req_devfn, req_regnum, req_be, req_write, req_wdata}}, 32'd1);
        end
        cap_bus = req_bus; cap_devfn = req_devfn; cap_regnum = req_regnum;
        cap_be = req_be; cap_write = req_write; cap_wdata = req_wdata;
        n_req++;
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        repeat (cpl_dly) @(negedge clk);
        cpl_data  = cpl_pat;
        cpl_valid = 1'b1;
        @(negedge clk);
        cpl_valid = 1'b0;
        cpl_data  = '0;
      end
    end
  end

  task automatic acc(input logic we, input logic [12:0] addr, input logic [31:0] wd,
                     input logic [3:0] st, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    hb_req = 1'b1; hb_we = we; hb_addr = addr; hb_wdata = wd; hb_wstrb = st;
    cyc = 0;
    #1;
    while (!hb_ack && cyc < 2000) begin
      @(negedge clk);
      #1;
      cyc++;
    end
    rd = hb_rdata;
    @(negedge clk);
    hb_req = 1'b0; hb_we = 1'b0; hb_addr = '0; hb_wdata = '0; hb_wstrb = '0;
  endtask

  typedef struct packed {
    logic [20:0] hdr;
    logic        we;
    logic [11:0] ofs;
    logic [31:0] wdata;
    logic [3:0]  wstrb;
    logic [3:0]  be;
    logic [9:0]  regnum;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{21'h141234, 1'b1, 12'h006, 32'h00AB0000, 4'hF, 4'h4, 10'h001},
    '{21'h1C0108, 1'b0, 12'h0FE, 32'h0,        4'h0, 4'hC, 10'h03F},
    '{21'h03FFFF, 1'b1, 12'hFFC, 32'h12345678, 4'h6, 4'h6, 10'h3FF},
    '{21'h000000, 1'b0, 12'h010, 32'h0,        4'h0, 4'hF, 10'h004},
    '{21'h1F8001, 1'b1, 12'h100, 32'hDEADBEEF, 4'h1, 4'hF, 10'h040},
    '{21'h112345, 1'b0, 12'h003, 32'h0,        4'h0, 4'h1, 10'h000}
  };

  initial begin
    logic [31:0] rd;
    int cyc, base;
    hb_req = 0; hb_we = 0; hb_addr = '0; hb_wdata = '0; hb_wstrb = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 req_valid", {31'b0, req_valid}, 32'd0);
    acc(0, 13'h140, 0, 0, rd, cyc);
    check("R1 header zero", rd, 32'd0);

    // R2 readback masking
    acc(1, 13'h140, 32'hFFFFFFFF, 4'hF, rd, cyc);
    acc(0, 13'h140, 0, 0, rd, cyc);
    check("R2 header mask", rd, 32'h001FFFFF);

    // Vector table: R3 R4 R5 R6 R8
    for (int i = 0; i < 6; i++) begin
      rdy_dly = 0; cpl_dly = 1; cpl_pat = 32'hC0DE0000 + i;
      acc(1, 13'h140, {11'b0, VECS[i].hdr}, 4'hF, rd, cyc);
      acc(VECS[i].we, {1'b1, VECS[i].ofs}, VECS[i].wdata, VECS[i].wstrb, rd, cyc);
      check("R3 bus", {24'b0, cap_bus}, {24'b0, VECS[i].hdr[15:8]});
      check("R3 devfn", {24'b0, cap_devfn}, {24'b0, VECS[i].hdr[7:0]});
      check("R3 regnum", {22'b0, cap_regnum}, {22'b0, VECS[i].regnum});
      check(VECS[i].hdr[20] ? "R4 forced be" : "R5 derived be", {28'b0, cap_be}, {28'b0, VECS[i].be});
      check("R6 write flag", {31'b0, cap_write}, {31'b0, VECS[i].we});
      if (VECS[i].we) check("R6 wdata", cap_wdata, VECS[i].wdata);
      else            check("R8 read data", rd, cpl_pat);
    end
    acc(0, 13'h140, 0, 0, rd, cyc);   // drain last completion path

    // R8 exact latencies
    acc(1, 13'h140, 32'h0, 4'hF, rd, cyc);
    rdy_dly = 3; cpl_dly = 2;
    acc(1, 13'h1020, 32'h1, 4'hF, rd, cyc);
    check("R8 write ack cycle", cyc, 32'd4);
    repeat (8) @(negedge clk);
    rdy_dly = 0; cpl_dly = 5; cpl_pat = 32'hA5A55A5A;
    acc(0, 13'h1024, 0, 0, rd, cyc);
    check("R8 read ack cycle", cyc, 32'd7);
    check("R8 read data", rd, 32'hA5A55A5A);
    repeat (4) @(negedge clk);

    // R9 stall behind outstanding write, R11 header access meanwhile
    rdy_dly = 0; cpl_dly = 12; cpl_pat = 32'h77;
    base = n_req;
    acc(1, 13'h1030, 32'h5, 4'hF, rd, cyc);
    acc(1, 13'h140, 32'h00010203, 4'hF, rd, cyc);
    check("R11 header ack in WAIT", cyc, 32'd0);
    check("R9 no new request yet", n_req, base + 1);
    acc(0, 13'h1034, 0, 0, rd, cyc);
    check("R9 stalled read", {31'b0, cyc >= 20}, 32'd1);
    check("R9 request count", n_req, base + 2);
    check("R8 data after stall", rd, 32'h77);
    repeat (4) @(negedge clk);

    // R10 stray address
    acc(1, 13'h0200, 32'hFFFFFFFF, 4'hF, rd, cyc);
    check("R10 stray write ack", cyc, 32'd0);
    acc(0, 13'h0200, 0, 0, rd, cyc);
    check("R10 stray read zero", rd, 32'd0);
    acc(0, 13'h140, 0, 0, rd, cyc);
    check("R10 header untouched", rd, 32'h00010203);
    check("R10 no request", n_req, base + 2);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule